// File: doc/BRIEF.md
# Serial Peripheral Master with Receive-Alarm Interrupt

This block is a serial peripheral master placed on a simple word-addressed register bus. Software pushes 8-bit words into a transmit queue. The block clocks each word out on `mosi` with a generated `sclk` and samples `miso` at the same time, so each word sent produces exactly one received word in a receive queue. An active-low frame select, `csN`, frames a run of words. Software closes the frame by marking the final word with an end-of-frame tag. The tag is armed by a register write just before that word is pushed.

Software normally batches its work. It fills the transmit queue and then waits for the interrupt. When the interrupt arrives, it reads the receive occupancy and drains exactly that many words. The interrupt has two modes. In fill-level mode it fires once the number of free receive slots falls to a programmed alarm value or below. In ready mode it fires as soon as one word is waiting, which covers a single-word transfer that never reaches any fill level.

Top module: `spim_top`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, `irq` is 0, and both the receive count (address 6) and the status register (address 8) read 0.
- R2: The clock-phase select is MODE (address 1) bit 12 and the clock-polarity select is bit 13. While no frame is open, `sclk` rests at the polarity value. With phase 0, `miso` is sampled on the edge that leaves the rest level. With phase 1, it is sampled on the edge that returns to it.
- R3: MODE bit 28 set shifts words least-significant bit first. Clear, they shift most-significant bit first.
- R4: One `sclk` period lasts divider+1 clock cycles, where the divider is bits 7:0 of address 2. A divider of 0 acts as 1.
- R5: Words leave the transmit queue only while the transmitter is enabled. Each word sent is captured into the receive queue when the receiver is enabled. Address 3 is a command register: bit 0 enables TX, bit 1 disables TX, bit 2 enables RX, bit 3 disables RX, bit 4 resets RX, bit 5 resets TX.
- R6: Writing 1 to bit 0 of address 4 tags the next word written to the data register (address 0). `csN` goes high once that word has shifted out. Between untagged words, including while the queue is empty, `csN` stays low.
- R7: `csN` falls ceil((divider+1)/2) clock cycles before the first `sclk` edge, and no `sclk` edge occurs in the cycle where it falls.
- R8: Address 6 returns the number of waiting receive words, never more than the depth. Reads of address 0 return the words in arrival order. A read of address 0 with the queue empty returns 0.
- R9: When MODE bit 0 is 1 (fill-level mode), the ready status (address 8 bit 0) is 1 exactly when depth minus receive count is at most the alarm value at address 5.
- R10: When MODE bit 0 is 0, the ready status is 1 exactly when at least one receive word is waiting.
- R11: `irq` equals the ready status ANDed with bit 0 of the mask register at address 7. Writing 0 to the mask silences `irq`.
- R12: A data write while the transmit queue is full is dropped and sets a sticky overrun flag, status bit 1.
- R13: The TX reset command empties the transmit queue, clears the overrun flag and any armed end-of-frame tag, and returns the shifter to idle. The RX reset command empties the receive queue and also returns the shifter to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Synchronous reset, active low |
| busSel | input | 1 | Bus access strobe |
| busWr | input | 1 | 1 for a write access, 0 for a read access |
| busAddr | input | 4 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from the address |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | 1 | Frame select, active low |
| irq | output | 1 | Receive interrupt |

## Verification
The checker watches five properties on every cycle:
- `sclk` sits at the polarity level whenever the frame is closed.
- No clock edge coincides with the falling edge of `csN`.
- A ready-mode interrupt never fires with an empty receive queue.
- The receive count never exceeds the depth.
- A write to a full transmit queue always leaves the overrun flag set.

Several behaviours need the bench's directed scenarios to show them:
- the bit order seen on the wire;
- the measured `sclk` period;
- the lead time of `csN`;
- the frame held open across an empty queue;
- the exact alarm threshold crossing;
- the effect of the reset commands on a pending tag.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // strobes from the register control to the datapath
  typedef struct packed {
    logic txPush;
    logic txTag;
    logic rxPop;
    logic txClear;
    logic rxClear;
  } spimStrobe_t;

  typedef enum logic [2:0] {
    SH_IDLE, SH_SETUP, SH_FIRST, SH_SECOND, SH_HOLD
  } shState_t;

  localparam logic [3:0] ADDR_DATA   = 4'd0;
  localparam logic [3:0] ADDR_MODE   = 4'd1;
  localparam logic [3:0] ADDR_CLKDIV = 4'd2;
  localparam logic [3:0] ADDR_CMD    = 4'd3;
  localparam logic [3:0] ADDR_EOF    = 4'd4;
  localparam logic [3:0] ADDR_ALARM  = 4'd5;
  localparam logic [3:0] ADDR_RXCNT  = 4'd6;
  localparam logic [3:0] ADDR_IMASK  = 4'd7;
  localparam logic [3:0] ADDR_STATUS = 4'd8;

  localparam int MODE_FULL_BIT = 0;
  localparam int MODE_CPHA_BIT = 12;
  localparam int MODE_CPOL_BIT = 13;
  localparam int MODE_LSB_BIT  = 28;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       clear,
  input  logic                       push,
  input  logic [WIDTH-1:0]           pushData,
  input  logic                       pop,
  output logic [WIDTH-1:0]           head,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic doPush, doPop;

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (doPush) mem[wp] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (doPush) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (doPop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end
endmodule

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  spimStrobe_t                strb,
  input  logic [7:0]                 txData,
  input  logic                       cpha,
  input  logic                       cpol,
  input  logic                       lsbFirst,
  input  logic [7:0]                 clkDiv,
  input  logic                       txEn,
  input  logic                       rxEn,
  input  logic                       miso,
  output logic                       sclk,
  output logic                       mosi,
  output logic                       csN,
  output logic                       txFull,
  output logic [$clog2(DEPTH+1)-1:0] rxCount,
  output logic [7:0]                 rxHead
);
  localparam int CW = $clog2(DEPTH+1);

  logic [8:0] txHead;
  logic txEmpty, txPop, rxPush;
  logic unusedRxFull, unusedRxEmpty;
  logic [CW-1:0] unusedTxCount;

  spim_fifo #(.WIDTH(9), .DEPTH(DEPTH)) uTxFifo (
    .clk(clk), .rstN(rstN), .clear(strb.txClear),
    .push(strb.txPush), .pushData({strb.txTag, txData}), .pop(txPop),
    .head(txHead), .full(txFull), .empty(txEmpty), .count(unusedTxCount)
  );

  logic [7:0] rxShift;
  spim_fifo #(.WIDTH(8), .DEPTH(DEPTH)) uRxFifo (
    .clk(clk), .rstN(rstN), .clear(strb.rxClear),
    .push(rxPush), .pushData(rxShift), .pop(strb.rxPop),
    .head(rxHead), .full(unusedRxFull), .empty(unusedRxEmpty), .count(rxCount)
  );

  // half-period lengths: first half gets the extra cycle of an odd period
  logic [7:0] effDiv;
  logic [8:0] period, firstLen, secondLen;
  assign effDiv    = (clkDiv == 8'd0) ? 8'd1 : clkDiv;
  assign period    = {1'b0, effDiv} + 9'd1;
  assign firstLen  = (period + 9'd1) >> 1;
  assign secondLen = period - firstLen;

  shState_t st;
  logic [8:0] cnt;
  logic [2:0] bitIdx;
  logic [7:0] shiftQ;
  logic lastQ;
  logic firstDone, secondDone, canLoad, wordEnd, flush;

  assign firstDone  = (cnt == firstLen - 9'd1);
  assign secondDone = (cnt == secondLen - 9'd1);
  assign canLoad    = txEn && !txEmpty;
  assign wordEnd    = (st == SH_SECOND) && secondDone && (bitIdx == 3'd7);
  assign flush      = strb.txClear || strb.rxClear;
  assign txPop      = canLoad && ((st == SH_IDLE) || (st == SH_HOLD) || (wordEnd && !lastQ));
  assign rxPush     = wordEnd && rxEn;

  always_ff @(posedge clk) begin
    if (!rstN || flush) begin
      st <= SH_IDLE;
      cnt <= '0;
      bitIdx <= '0;
      shiftQ <= '0;
      rxShift <= '0;
      lastQ <= 1'b0;
    end else begin
      case (st)
        SH_IDLE: if (canLoad) begin
          shiftQ <= txHead[7:0];
          lastQ <= txHead[8];
          bitIdx <= '0;
          cnt <= '0;
          st <= cpha ? SH_SETUP : SH_FIRST;
        end
        SH_SETUP: if (firstDone) begin
          cnt <= '0;
          st <= SH_FIRST;
        end else cnt <= cnt + 9'd1;
        SH_FIRST: if (firstDone) begin
          cnt <= '0;
          st <= SH_SECOND;
          rxShift <= lsbFirst ? {miso, rxShift[7:1]} : {rxShift[6:0], miso};
        end else cnt <= cnt + 9'd1;
        SH_SECOND: if (secondDone) begin
          cnt <= '0;
          if (bitIdx == 3'd7) begin
            if (lastQ) st <= SH_IDLE;
            else if (canLoad) begin
              shiftQ <= txHead[7:0];
              lastQ <= txHead[8];
              bitIdx <= '0;
              st <= SH_FIRST;
            end else st <= SH_HOLD;
          end else begin
            bitIdx <= bitIdx + 3'd1;
            shiftQ <= lsbFirst ? (shiftQ >> 1) : (shiftQ << 1);
            st <= SH_FIRST;
          end
        end else cnt <= cnt + 9'd1;
        SH_HOLD: if (canLoad) begin
          shiftQ <= txHead[7:0];
          lastQ <= txHead[8];
          bitIdx <= '0;
          cnt <= '0;
          st <= SH_FIRST;
        end
        default: st <= SH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (st)
      SH_FIRST:  sclk = cpol ^ cpha;
      SH_SECOND: sclk = ~(cpol ^ cpha);
      default:   sclk = cpol;
    endcase
  end

  assign mosi = ((st == SH_FIRST) || (st == SH_SECOND)) ? (lsbFirst ? shiftQ[0] : shiftQ[7]) : 1'b0;
  assign csN  = (st == SH_IDLE);
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       busSel,
  input  logic                       busWr,
  input  logic [3:0]                 busAddr,
  input  logic [31:0]                busWdata,
  output logic [31:0]                busRdata,
  input  logic                       txFull,
  input  logic [$clog2(DEPTH+1)-1:0] rxCount,
  input  logic [7:0]                 rxHead,
  output spimStrobe_t                strb,
  output logic [7:0]                 txData,
  output logic                       cpha,
  output logic                       cpol,
  output logic                       lsbFirst,
  output logic                       fullMode,
  output logic [7:0]                 clkDiv,
  output logic                       txEn,
  output logic                       rxEn,
  output logic                       overrun,
  output logic                       rxReady,
  output logic                       irq
);
  localparam int CW = $clog2(DEPTH+1);

  logic wrAcc, rdAcc, cmdWr, dataWr;
  logic eofPending, imask;
  logic [CW-1:0] alarmQ, freeSlots;
  logic unusedOk;

  assign unusedOk = ^busWdata;
  assign wrAcc  = busSel && busWr;
  assign rdAcc  = busSel && !busWr;
  assign cmdWr  = wrAcc && (busAddr == ADDR_CMD);
  assign dataWr = wrAcc && (busAddr == ADDR_DATA);

  assign strb.txPush  = dataWr;
  assign strb.txTag   = eofPending;
  assign strb.rxPop   = rdAcc && (busAddr == ADDR_DATA);
  assign strb.txClear = cmdWr && busWdata[5];
  assign strb.rxClear = cmdWr && busWdata[4];
  assign txData = busWdata[7:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpha <= 1'b0; cpol <= 1'b0; lsbFirst <= 1'b0; fullMode <= 1'b0;
      clkDiv <= 8'h13;
      alarmQ <= '0;
      imask <= 1'b0;
      txEn <= 1'b0; rxEn <= 1'b0;
      eofPending <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (wrAcc && busAddr == ADDR_MODE) begin
        fullMode <= busWdata[MODE_FULL_BIT];
        cpha     <= busWdata[MODE_CPHA_BIT];
        cpol     <= busWdata[MODE_CPOL_BIT];
        lsbFirst <= busWdata[MODE_LSB_BIT];
      end
      if (wrAcc && busAddr == ADDR_CLKDIV) clkDiv <= busWdata[7:0];
      if (wrAcc && busAddr == ADDR_ALARM)  alarmQ <= busWdata[CW-1:0];
      if (wrAcc && busAddr == ADDR_IMASK)  imask  <= busWdata[0];
      if (cmdWr) begin
        if (busWdata[0]) txEn <= 1'b1;
        if (busWdata[1]) txEn <= 1'b0;
        if (busWdata[2]) rxEn <= 1'b1;
        if (busWdata[3]) rxEn <= 1'b0;
      end
      if (strb.txClear) eofPending <= 1'b0;
      else if (wrAcc && busAddr == ADDR_EOF && busWdata[0]) eofPending <= 1'b1;
      else if (dataWr) eofPending <= 1'b0;
      if (strb.txClear) overrun <= 1'b0;
      else if (dataWr && txFull) overrun <= 1'b1;
    end
  end

  assign freeSlots = CW'(DEPTH) - rxCount;
  assign rxReady   = fullMode ? (freeSlots <= alarmQ) : (rxCount != '0);
  assign irq       = rxReady && imask;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_DATA:   busRdata = (rxCount == '0) ? 32'd0 : {24'd0, rxHead};
      ADDR_MODE:   begin
        busRdata[MODE_FULL_BIT] = fullMode;
        busRdata[MODE_CPHA_BIT] = cpha;
        busRdata[MODE_CPOL_BIT] = cpol;
        busRdata[MODE_LSB_BIT]  = lsbFirst;
      end
      ADDR_CLKDIV: busRdata = {24'd0, clkDiv};
      ADDR_ALARM:  busRdata = 32'(alarmQ);
      ADDR_RXCNT:  busRdata = 32'(rxCount);
      ADDR_IMASK:  busRdata = {31'd0, imask};
      ADDR_STATUS: busRdata = {30'd0, overrun, rxReady};
      default:     busRdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_top.sv
module spim_top
  import spim_pkg::*;
#(
  parameter int DEPTH = 512
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso,
  output logic        csN,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH+1);

  spimStrobe_t strb;
  logic [7:0] txData, rxHead, clkDiv;
  logic [CW-1:0] rxCount;
  logic cpha, cpol, lsbFirst, fullMode, txEn, rxEn, txFull, overrun, rxReady;

  spim_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .txFull(txFull), .rxCount(rxCount),
    .rxHead(rxHead), .strb(strb), .txData(txData), .cpha(cpha), .cpol(cpol),
    .lsbFirst(lsbFirst), .fullMode(fullMode), .clkDiv(clkDiv), .txEn(txEn),
    .rxEn(rxEn), .overrun(overrun), .rxReady(rxReady), .irq(irq)
  );

  spim_datapath #(.DEPTH(DEPTH)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .txData(txData), .cpha(cpha), .cpol(cpol),
    .lsbFirst(lsbFirst), .clkDiv(clkDiv), .txEn(txEn), .rxEn(rxEn), .miso(miso),
    .sclk(sclk), .mosi(mosi), .csN(csN), .txFull(txFull), .rxCount(rxCount),
    .rxHead(rxHead)
  );
endmodule

// File: rtl/spim_chk.sv
module spim_chk #(
  parameter int DEPTH = 512
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       csN,
  input logic                       sclk,
  input logic                       cpol,
  input logic                       irq,
  input logic                       fullMode,
  input logic [$clog2(DEPTH+1)-1:0] rxCount,
  input logic                       txPush,
  input logic                       txFull,
  input logic                       overrun
);
  AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (sclk == cpol)); // R2

  AST_CS_FALL_NO_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (sclk == cpol)); // R7

  AST_READY_HAS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !fullMode) |-> (rxCount != '0)); // R10

  AST_RX_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount <= ($clog2(DEPTH+1))'(DEPTH))); // R8

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (txPush && txFull) |=> overrun); // R12
endmodule

bind spim_top spim_chk #(.DEPTH(DEPTH)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .cpol(cpol), .irq(irq),
  .fullMode(fullMode), .rxCount(rxCount), .txPush(strb.txPush), .txFull(txFull),
  .overrun(overrun)
);

// File: tb/sim_spim_top.sv
`timescale 1ns/1ps
module sim_spim_top;
  localparam int DEPTH = 16;
  localparam logic [3:0] A_DATA = 4'd0, A_MODE = 4'd1, A_DIV = 4'd2, A_CMD = 4'd3,
    A_EOF = 4'd4, A_ALARM = 4'd5, A_RXCNT = 4'd6, A_MASK = 4'd7, A_STAT = 4'd8;

  logic clk = 1'b0, rstN = 1'b0;
  logic busSel = 1'b0, busWr = 1'b0;
  logic [3:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic sclk, mosi, miso, csN, irq;

  always #2.5 clk = ~clk;
  assign miso = mosi;  // loopback slave

  spim_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN), .irq(irq)
  );

  int nChecks = 0, nFails = 0;

  // wire monitor
  logic tbCpol = 1'b0, tbCpha = 1'b0, lead;
  logic [7:0] capShift = '0, lastCap = '0;
  int capBits = 0, capWords = 0, edgesInFrame = 0, csRises = 0;
  realtime lastLead = 0, leadPeriod = 0, csFallT = 0, firstEdgeT = 0;

  always @(negedge csN) begin
    csFallT = $realtime; edgesInFrame = 0; capBits = 0; capWords = 0;
  end
  always @(posedge csN) csRises++;
  always @(sclk) if (csN === 1'b0) begin
    if (edgesInFrame == 0) firstEdgeT = $realtime;
    edgesInFrame++;
    lead = (sclk != tbCpol);
    if (lead) begin leadPeriod = $realtime - lastLead; lastLead = $realtime; end
    if (lead != tbCpha) begin
      capShift = {capShift[6:0], mosi};
      capBits++;
      if (capBits % 8 == 0) begin lastCap = capShift; capWords++; end
    end
  end

  task automatic checkEq(input string req, input string what, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWr = 0; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busSel = 0;
  endtask

  task automatic waitFrameEnd();
    int t = 0;
    repeat (4) @(negedge clk);
    while (!csN && t < 4000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    checkEq("R1", "csN", csN, 1);
    checkEq("R1", "sclk", sclk, 0);
    checkEq("R1", "irq", irq, 0);
    rd(A_RXCNT, d); checkEq("R1", "rx count", d, 0);
    rd(A_STAT, d);  checkEq("R1", "status", d, 0);
  endtask

  task automatic testMode0();
    logic [31:0] d;
    tbCpol = 0; tbCpha = 0;
    wr(A_DIV, 3); wr(A_CMD, 32'h5);
    wr(A_EOF, 1); wr(A_DATA, 8'hA5);
    waitFrameEnd();
    checkEq("R3", "msb-first wire byte", lastCap, 8'hA5);
    checkEq("R4", "sclk period ns", longint'(leadPeriod), 20);
    checkEq("R7", "cs lead ns", longint'(firstEdgeT - csFallT), 10);
    rd(A_RXCNT, d); checkEq("R5", "one word returned", d, 1);
    rd(A_DATA, d);  checkEq("R8", "rx word", d, 8'hA5);
    rd(A_DATA, d);  checkEq("R8", "empty read", d, 0);
  endtask

  task automatic testMode3Lsb();
    logic [31:0] d;
    wr(A_MODE, (32'd1 << 12) | (32'd1 << 13) | (32'd1 << 28));
    tbCpol = 1; tbCpha = 1;
    repeat (2) @(negedge clk);
    checkEq("R2", "idle sclk with polarity 1", sclk, 1);
    csRises = 0;
    wr(A_DATA, 8'h3C); wr(A_DATA, 8'h81); wr(A_EOF, 1); wr(A_DATA, 8'h96);
    waitFrameEnd();
    checkEq("R3", "lsb-first wire byte", lastCap, 8'h69);
    checkEq("R6", "words in one frame", capWords, 3);
    checkEq("R6", "cs rises", csRises, 1);
    checkEq("R2", "sclk back at rest", sclk, 1);
    rd(A_DATA, d); checkEq("R8", "order 0", d, 8'h3C);
    rd(A_DATA, d); checkEq("R8", "order 1", d, 8'h81);
    rd(A_DATA, d); checkEq("R5", "order 2", d, 8'h96);
  endtask

  task automatic testTxGate();
    logic [31:0] d;
    wr(A_MODE, 0); tbCpol = 0; tbCpha = 0;
    wr(A_CMD, 32'h2);
    wr(A_EOF, 1); wr(A_DATA, 8'h5A);
    repeat (50) @(negedge clk);
    checkEq("R5", "no frame while tx disabled", csN, 1);
    rd(A_RXCNT, d); checkEq("R5", "nothing received", d, 0);
    wr(A_CMD, 32'h1);
    waitFrameEnd();
    rd(A_DATA, d); checkEq("R5", "sent after enable", d, 8'h5A);
  endtask

  task automatic testReadyIrq();
    logic [31:0] d;
    wr(A_MASK, 1);
    checkEq("R11", "irq with empty rx", irq, 0);
    wr(A_EOF, 1); wr(A_DATA, 8'h11);
    waitFrameEnd();
    checkEq("R11", "irq on one word", irq, 1);
    rd(A_STAT, d); checkEq("R10", "ready bit", d & 1, 1);
    wr(A_MASK, 0);
    checkEq("R11", "irq masked", irq, 0);
    rd(A_DATA, d);
    rd(A_STAT, d); checkEq("R10", "ready clears when drained", d & 1, 0);
  endtask

  task automatic testAlarm();
    logic [31:0] d;
    wr(A_MODE, 1); wr(A_ALARM, 3);
    for (int i = 0; i < 12; i++) wr(A_DATA, 8'h20 + i);
    repeat (500) @(negedge clk);
    checkEq("R6", "frame held open", csN, 0);
    rd(A_RXCNT, d); checkEq("R9", "count 12", d, 12);
    rd(A_STAT, d);  checkEq("R9", "4 free above alarm", d & 1, 0);
    wr(A_EOF, 1); wr(A_DATA, 8'h2C);
    waitFrameEnd();
    rd(A_STAT, d);  checkEq("R9", "3 free at alarm", d & 1, 1);
    for (int i = 0; i < 13; i++) begin
      rd(A_DATA, d); checkEq("R8", "drain order", d, 8'h20 + i);
    end
    rd(A_STAT, d); checkEq("R9", "ready after drain", d & 1, 0);
  endtask

  task automatic testOverrunReset();
    logic [31:0] d;
    wr(A_MODE, 0);
    wr(A_CMD, 32'h2);
    for (int i = 0; i < 17; i++) wr(A_DATA, i);
    rd(A_STAT, d); checkEq("R12", "overrun set", (d >> 1) & 1, 1);
    wr(A_CMD, 32'h20);
    rd(A_STAT, d); checkEq("R13", "overrun cleared", (d >> 1) & 1, 0);
    wr(A_CMD, 32'h1);
    repeat (40) @(negedge clk);
    checkEq("R13", "tx queue emptied", csN, 1);
    wr(A_EOF, 1); wr(A_CMD, 32'h20);
    wr(A_DATA, 8'h77);
    repeat (60) @(negedge clk);
    checkEq("R13", "tag dropped by tx reset", csN, 0);
    wr(A_EOF, 1); wr(A_DATA, 8'h78);
    waitFrameEnd();
    rd(A_RXCNT, d); checkEq("R5", "two returned", d, 2);
    wr(A_CMD, 32'h10);
    rd(A_RXCNT, d); checkEq("R13", "rx reset empties", d, 0);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
    testReset();
    testMode0();
    testMode3Lsb();
    testTxGate();
    testReadyIrq();
    testAlarm();
    testOverrunReset();
    finishRun();
  end
endmodule